// File: doc/BRIEF.md
# A/D Conversion Scan Sequencer

This block is the digital controller that sits in front of an eight-input, 10-bit analog-to-digital converter. The converter is seen as a plain handshake: the sequencer raises a one-clock start strobe together with a channel number, and the converter later returns a one-clock done strobe carrying the 10-bit code. The sequencer is always ready to take that code, so the done strobe acts as a valid with no back-pressure. The converter must give one done for each start and never a done without a start outstanding.

Two modes are offered. In single mode, one chosen channel is converted once. In scan mode, conversion walks upward from a chosen first channel to channel 7. It then either stops with a finish flag or wraps back to the first channel and keeps going. Each code lands in a register that belongs to its channel alone. A programmable settling count sets the time between conversions. A halt request ends the run once the conversion in flight is complete.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, fin, upd and adc_start are 0 and all eight result registers hold 0.
- R2: With scan_mode = 0, an accepted go converts channel first_ch exactly once. The block then returns to idle with fin = 1.
- R3: With scan_mode = 1, the conversions run on channels first_ch, first_ch+1, ... 7 in ascending order, and adc_chan carries the channel number while adc_start is high.
- R4: The code returned with adc_done is written to the result register of the channel being converted, and no other result register changes. Register k occupies bits [10k+9:10k] of results.
- R5: adc_start is high for exactly one clock per conversion. No new start is issued until the done for the previous one has been taken.
- R6: adc_start goes high conv_time+1 clocks after the edge that accepts go, and conv_time+1 clocks after the edge that accepts a done that leads to a further conversion. conv_time is sampled when go is accepted.
- R7: With cont_scan = 1 in scan mode, the conversion after channel 7 is on first_ch again, and the run does not end by itself.
- R8: With cont_scan = 0 in scan mode, the run stops after channel 7 and fin rises. fin stays high while idle and is cleared when the next go is accepted.
- R9: go while busy is ignored: the channel sequence, mode and settling count of the running job are unchanged.
- R10: halt while a conversion is outstanding lets that conversion complete and store its result, then goes idle with fin = 0. halt during the settling interval goes idle at once with no further start.
- R11: upd is a one-clock pulse on the clock after each result is written, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, taken only when idle |
| halt | input | 1 | Stop request, applied after the conversion in flight |
| scan_mode | input | 1 | 0 = single channel, 1 = scan to channel 7 |
| cont_scan | input | 1 | In scan mode, wrap to first channel after channel 7 |
| first_ch | input | 3 | Chosen channel (single) or first channel (scan) |
| conv_time | input | 8 | Settling clocks before each start, minus one |
| adc_start | output | 1 | One-clock conversion strobe to the converter |
| adc_chan | output | 3 | Channel to convert |
| adc_done | input | 1 | Converter result strobe |
| adc_data | input | 10 | Converter result code |
| results | output | 80 | Eight 10-bit per-channel result registers, channel k at [10k+9:10k] |
| busy | output | 1 | A job is in progress |
| fin | output | 1 | Last job ended normally |
| upd | output | 1 | A result register was written on the previous edge |

## Verification
The checks assume that the converter answers each start with exactly one done, one or more clocks later, and never raises done with nothing outstanding. This assumption is itself stated as a property. The bench's converter model meets it by keeping a single countdown that is armed only when it sees a start and fires done once. Its latency varies from one to four clocks so that the settling and waiting phases are both exercised. Mode, first channel and settling count are changed only while the block is idle, except in the deliberate go-while-busy case.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_LAUNCH = 2'd2,
    SQ_WAIT   = 2'd3
  } sq_state_t;
endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int N_CH  = 8,
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [RES_W-1:0]      wr_data,
  output logic [N_CH*RES_W-1:0] regs_flat
);
  for (genvar k = 0; k < N_CH; k++) begin : g_slot
    logic [RES_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_q <= '0;
      else if (wr_en && (wr_ch == CH_W'(k)))      slot_q <= wr_data;
    end
    assign regs_flat[k*RES_W +: RES_W] = slot_q;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CH_W  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic             scan_mode,
  input  logic             cont_scan,
  input  logic [CH_W-1:0]  first_ch,
  input  logic [CNT_W-1:0] conv_time,
  input  logic             adc_done,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             adc_start,
  output logic [CH_W-1:0]  adc_chan,
  output logic             wr_en,
  output logic             busy,
  output logic             fin,
  output logic             upd
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  sq_state_t        st_q;
  logic [CH_W-1:0]  ch_q, first_q;
  logic [CNT_W-1:0] ctime_q;
  logic             scan_q, cont_q, halt_pend_q, fin_q, upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= SQ_IDLE;
      ch_q        <= '0;
      first_q     <= '0;
      ctime_q     <= '0;
      scan_q      <= 1'b0;
      cont_q      <= 1'b0;
      halt_pend_q <= 1'b0;
      fin_q       <= 1'b0;
      upd_q       <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (go) begin
          st_q        <= SQ_SETTLE;
          ch_q        <= first_ch;
          first_q     <= first_ch;
          ctime_q     <= conv_time;
          scan_q      <= scan_mode;
          cont_q      <= cont_scan;
          fin_q       <= 1'b0;
          halt_pend_q <= 1'b0;
        end
        SQ_SETTLE: begin
          if (halt)             st_q <= SQ_IDLE;
          else if (tmr_expired) st_q <= SQ_LAUNCH;
        end
        SQ_LAUNCH: begin
          st_q <= SQ_WAIT;
          if (halt) halt_pend_q <= 1'b1;
        end
        SQ_WAIT: begin
          if (adc_done) begin
            upd_q <= 1'b1;
            if (halt_pend_q || halt) begin
              st_q <= SQ_IDLE;
            end else if (!scan_q) begin
              st_q  <= SQ_IDLE;
              fin_q <= 1'b1;
            end else if (ch_q == LAST_CH) begin
              if (cont_q) begin
                ch_q <= first_q;
                st_q <= SQ_SETTLE;
              end else begin
                st_q  <= SQ_IDLE;
                fin_q <= 1'b1;
              end
            end else begin
              ch_q <= ch_q + 1'b1;
              st_q <= SQ_SETTLE;
            end
          end else if (halt) begin
            halt_pend_q <= 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign tmr_load  = (st_q != SQ_SETTLE);
  assign tmr_val   = (st_q == SQ_IDLE) ? conv_time : ctime_q;
  assign adc_start = (st_q == SQ_LAUNCH);
  assign adc_chan  = ch_q;
  assign wr_en     = (st_q == SQ_WAIT) && adc_done;
  assign busy      = (st_q != SQ_IDLE);
  assign fin       = fin_q;
  assign upd       = upd_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter  int N_CH  = 8,
  parameter  int RES_W = 10,
  parameter  int CNT_W = 8,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  halt,
  input  logic                  scan_mode,
  input  logic                  cont_scan,
  input  logic [CH_W-1:0]       first_ch,
  input  logic [CNT_W-1:0]      conv_time,
  output logic                  adc_start,
  output logic [CH_W-1:0]       adc_chan,
  input  logic                  adc_done,
  input  logic [RES_W-1:0]      adc_data,
  output logic [N_CH*RES_W-1:0] results,
  output logic                  busy,
  output logic                  fin,
  output logic                  upd
);
  logic             tmr_load, tmr_expired, wr_en;
  logic [CNT_W-1:0] tmr_val;

  adc_seq_fsm #(.N_CH(N_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .halt(halt),
    .scan_mode(scan_mode), .cont_scan(cont_scan), .first_ch(first_ch),
    .conv_time(conv_time), .adc_done(adc_done), .tmr_expired(tmr_expired),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .adc_start(adc_start),
    .adc_chan(adc_chan), .wr_en(wr_en), .busy(busy), .fin(fin), .upd(upd)
  );

  adc_settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  adc_result_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(adc_chan),
    .wr_data(adc_data), .regs_flat(results)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter  int N_CH  = 8,
  parameter  int RES_W = 10,
  parameter  int CNT_W = 8,
  localparam int CH_W  = $clog2(N_CH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  adc_start,
  input logic                  adc_done,
  input logic [N_CH*RES_W-1:0] results,
  input logic                  busy,
  input logic                  fin,
  input logic                  upd
);
  logic                  outstanding_q;
  logic [N_CH*RES_W-1:0] prev_q;
  logic [N_CH-1:0]       chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding_q <= 1'b0;
      prev_q        <= '0;
    end else begin
      prev_q <= results;
      if (adc_start)     outstanding_q <= 1'b1;
      else if (adc_done) outstanding_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_chg
    assign chg[k] = results[k*RES_W +: RES_W] != prev_q[k*RES_W +: RES_W];
  end

  a_r5_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !outstanding_q);
  a_r5_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |-> outstanding_q);
  a_r2_start_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
  a_r8_fin_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);
  a_r11_upd_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(adc_done));
  a_r4_one_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));
  a_r4_change_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |-> upd);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.N_CH(N_CH), .RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_done(adc_done),
  .results(results), .busy(busy), .fin(fin), .upd(upd)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0, halt = 1'b0, scan_mode = 1'b0, cont_scan = 1'b0;
  logic [2:0] first_ch = '0;
  logic [7:0] conv_time = '0;
  logic       adc_start, adc_done = 1'b0;
  logic [2:0] adc_chan;
  logic [9:0] adc_data = '0;
  logic [79:0] results;
  logic       busy, fin, upd;

  int total = 0, bad = 0, cycles = 0;
  int seen[$];
  int nconv = 0, cd = 0;

  always #4 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .halt(halt), .scan_mode(scan_mode),
    .cont_scan(cont_scan), .first_ch(first_ch), .conv_time(conv_time),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
    .adc_data(adc_data), .results(results), .busy(busy), .fin(fin), .upd(upd)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // converter model: one outstanding conversion, latency 1..4
  initial begin
    forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          adc_done = 1'b1;
          adc_data = 10'((seen[$] * 97 + nconv * 13 + 5) & 10'h3FF);
        end
      end
      if (rst_n && adc_start && cd == 0) begin
        seen.push_back(int'(adc_chan));
        nconv++;
        cd = 1 + (nconv % 4);
      end
    end
  end

  // behavioural reference model
  int m_ph = 0, m_cnt = 0, m_ch = 0, m_first = 0, m_ct = 0;
  bit m_scan = 0, m_cont = 0, m_hp = 0, m_fin = 0, m_upd = 0;
  int m_res[8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ch = 0; m_first = 0; m_ct = 0;
      m_scan = 0; m_cont = 0; m_hp = 0; m_fin = 0; m_upd = 0;
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      m_upd = 0;
      if (m_ph == 0) begin
        if (go) begin
          m_ph = 1; m_ch = first_ch; m_first = first_ch; m_ct = conv_time;
          m_cnt = conv_time; m_scan = scan_mode; m_cont = cont_scan;
          m_fin = 0; m_hp = 0;
        end
      end else if (m_ph == 1) begin
        if (halt) m_ph = 0;
        else if (m_cnt == 0) m_ph = 2;
        else m_cnt--;
      end else if (m_ph == 2) begin
        if (halt) m_hp = 1;
        m_ph = 3;
      end else begin
        if (adc_done) begin
          m_res[m_ch] = adc_data;
          m_upd = 1;
          if (m_hp || halt) m_ph = 0;
          else if (!m_scan) begin m_ph = 0; m_fin = 1; end
          else if (m_ch == 7) begin
            if (m_cont) begin m_ch = m_first; m_cnt = m_ct; m_ph = 1; end
            else begin m_ph = 0; m_fin = 1; end
          end else begin m_ch++; m_cnt = m_ct; m_ph = 1; end
        end else if (halt) m_hp = 1;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
      check(adc_start == (m_ph == 2), "R5 adc_start", adc_start, m_ph == 2);
      if (adc_start) check(int'(adc_chan) == m_ch, "R3 adc_chan", adc_chan, m_ch);
      check(fin == m_fin, "R8 fin", fin, m_fin);
      check(upd == m_upd, "R11 upd", upd, m_upd);
      for (int k = 0; k < 8; k++)
        check(int'(results[k*10 +: 10]) == m_res[k], "R4 result", results[k*10 +: 10], m_res[k]);
    end
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic launch(input bit sc, input bit ct_en, input int fc, input int ct, output int lag);
    @(negedge clk);
    seen.delete();
    scan_mode = sc; cont_scan = ct_en; first_ch = 3'(fc); conv_time = 8'(ct);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    lag = 1;
    while (!adc_start && lag < 1000) begin @(negedge clk); lag++; end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_seq(input string tag, input int from, input int upto);
    check(seen.size() == upto - from + 1, tag, seen.size(), upto - from + 1);
    for (int i = 0; i < seen.size() && i <= upto - from; i++)
      check(seen[i] == from + i, tag, seen[i], from + i);
  endtask

  initial begin
    int lag;
    repeat (3) @(negedge clk);
    check(!busy && !fin && !upd && !adc_start, "R1 flags", {busy, fin, upd, adc_start}, 0);
    check(results == '0, "R1 results", results[63:0], 0);
    rst_n = 1'b1;

    // single channel 3, settle 2
    launch(0, 0, 3, 2, lag);
    check(lag == 4, "R6 settle 2", lag, 4);
    wait_idle();
    expect_seq("R2 single ch3", 3, 3);
    check(fin == 1'b1, "R2 fin single", fin, 1);

    // single channel 0, settle 0
    launch(0, 0, 0, 0, lag);
    check(lag == 2, "R6 settle 0", lag, 2);
    wait_idle();
    expect_seq("R2 single ch0", 0, 0);

    // scan 5..7
    launch(1, 0, 5, 1, lag);
    wait_idle();
    expect_seq("R3 scan 5-7", 5, 7);
    check(fin == 1'b1, "R8 fin after scan", fin, 1);

    // full scan 0..7
    launch(1, 0, 0, 0, lag);
    wait_idle();
    expect_seq("R3 full scan", 0, 7);

    // scan from last channel only
    launch(1, 0, 7, 3, lag);
    wait_idle();
    expect_seq("R3 scan from 7", 7, 7);

    // go while busy ignored
    launch(1, 0, 4, 3, lag);
    check(fin == 1'b0, "R8 fin cleared on go", fin, 0);
    @(negedge clk);
    scan_mode = 1'b0; first_ch = 3'd0; conv_time = 8'd0; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_idle();
    expect_seq("R9 go while busy", 4, 7);

    // continuous from 6, halt after the fifth start
    launch(1, 1, 6, 1, lag);
    for (int i = 0; i < 3000 && seen.size() < 5; i++) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    wait_idle();
    check(seen.size() == 5, "R10 halt count", seen.size(), 5);
    if (seen.size() == 5) begin
      check(seen[2] == 6, "R7 wrap", seen[2], 6);
      check(seen[4] == 6, "R7 wrap again", seen[4], 6);
    end
    check(fin == 1'b0, "R10 no fin on halt", fin, 0);
    check(int'(results[60 +: 10]) == m_res[6], "R10 last result kept", results[60 +: 10], m_res[6]);

    // halt during settling
    @(negedge clk);
    seen.delete();
    scan_mode = 1'b1; cont_scan = 1'b0; first_ch = 3'd0; conv_time = 8'd10; go = 1'b1;
    @(negedge clk);
    go = 1'b0; halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    check(!busy, "R10 settle halt idle", busy, 0);
    repeat (15) @(negedge clk);
    check(seen.size() == 0, "R10 settle halt no start", seen.size(), 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule